// File: doc/BRIEF.md
# Video Controller Register Access Port

This block is the front end of a video display controller that faces the CPU. A byte-wide control port takes register writes as pairs of bytes. The first byte of a pair is the data value. The second byte carries the target register index, with bit 7 set to mark the pair as a register write. If bit 7 of the second byte is clear, the pair is a video-memory address setup: the block latches the address and reports it as a one-cycle strobe, and no register changes. A read of the control port returns one status byte, chosen by the low nibble of register 15. That read also re-arms the byte pairing, so the next control write counts as a first byte.

A second data path, the indirect port, streams bytes into the register chosen by register 17. The index in register 17 steps forward after each accepted byte unless its inhibit bit is set. This path uses a valid/ready handshake, with ready held high at all times: a byte is taken in every cycle in which valid is high, and the port never applies back-pressure.

A frame interrupt request is raised by a tick input. It stays pending until status register 0 is read. A write to register 46 starts a command: the block emits a one-cycle pulse together with the 4-bit command code and the 4-bit logic-operation code. The register file is presented flat on an output bus.

Top module: `vdp_reg_port`

## Requirements
- R1: A control write of a data byte D followed by a control write of 0x80|N, with N an implemented index, loads register N with D. The new value is visible on `regs_out[8N+7:8N]` one cycle after the second write. The target index is taken from bits 5..0 of the second byte.
- R2: When the second byte B2 of a pair has bit 7 clear, no register changes. One cycle later `vram_setup_stb` is high for one cycle, with `vram_setup_addr` = {B2[5:0], B1} and `vram_setup_wr` = B2[6].
- R3: Any control-port read makes the next control write a first byte, whatever pairing state it leaves behind.
- R4: `ctrl_rdata` shows status register S = R15[3:0]. S0 is {irq, s0_flags[6:0]}. S1..S9 are byte S-1 of `stat_in` (bits 8S-1..8S-8). Indices 10..15 read 0xFF.
- R5: `irq` rises one cycle after `frame_tick` and stays high until a control read while R15[3:0] = 0. A tick in the same cycle as that read keeps `irq` high.
- R6: Each byte accepted on the indirect port is written to register R17[5:0]. After the write, R17[5:0] increments modulo 64 unless R17[7] = 1. An indirect write whose target is register 17 itself replaces R17 and does not increment it.
- R7: Writes to indices 24..31 and 47..63 are ignored on both ports; those positions read 0 on `regs_out`.
- R8: A write to register 46 from either port gives a one-cycle `cmd_start` pulse in the cycle after the write. In that cycle `cmd_code` = R46[7:4] and `cmd_logop` = R46[3:0].
- R9: `vram_hi` always equals R14[2:0].
- R10: If both ports write the same register in one cycle, the control value wins. A control write in the same cycle as a control read is discarded.
- R11: After reset all registers are 0, `irq` is 0, the pairing expects a first byte, and `ind_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 8 | Control-port write byte |
| ctrl_rd | input | 1 | Control-port read strobe |
| ctrl_rdata | output | 8 | Selected status byte |
| ind_valid | input | 1 | Indirect-port byte valid |
| ind_ready | output | 1 | Indirect-port ready (always 1) |
| ind_data | input | 8 | Indirect-port byte |
| frame_tick | input | 1 | Frame interrupt event |
| s0_flags | input | 7 | Low bits of status 0 |
| stat_in | input | 72 | Status bytes 1..9 |
| irq | output | 1 | Pending frame interrupt |
| regs_out | output | 376 | Register file, byte N at bits 8N+7..8N |
| vram_hi | output | 3 | Upper video-memory address bits from R14 |
| vram_setup_stb | output | 1 | Address-setup pulse |
| vram_setup_addr | output | 14 | Latched setup address |
| vram_setup_wr | output | 1 | Setup direction bit |
| cmd_start | output | 1 | Command start pulse |
| cmd_code | output | 4 | Command code |
| cmd_logop | output | 4 | Logic operation code |

## Verification
The register path is swept over every 6-bit index with a value computed from the index. This separates implemented indices from holes and shows any decode that lands on the wrong byte. The status selector is swept over all sixteen pointer values, so each status byte and the 0xFF range are told apart. Directed pairs test pairing: the bit-7-clear setups with both values of the direction bit, a read that breaks a half-written pair, and a read in the same cycle as a write. The indirect path is tried with a plain run, a wrap past 63, the inhibit bit, a target of register 17 itself, register 46 as a target, and a same-cycle collision with the control port.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;
  localparam int IDX_W      = 6;
  localparam int R_VRAM_HI  = 14;
  localparam int R_STAT_SEL = 15;
  localparam int R_IND      = 17;
  localparam int R_CMD      = 46;
  localparam int HOLE_LO    = 24;
  localparam int HOLE_HI    = 31;
  localparam int SEL_W      = 4;
endpackage

// File: rtl/vdp_ctrl_seq.sv
module vdp_ctrl_seq
  import vdp_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [DW-1:0]       wdata,
  input  logic                rd,
  output logic                reg_we,
  output logic [IDX_W-1:0]    reg_idx,
  output logic [DW-1:0]       reg_data,
  output logic                vram_stb,
  output logic [IDX_W+DW-1:0] vram_addr,
  output logic                vram_wr
);
  localparam int AW = IDX_W + DW;

  logic          second;
  logic [DW-1:0] first_q;

  assign reg_we   = wr && !rd && second && wdata[DW-1];
  assign reg_idx  = wdata[IDX_W-1:0];
  assign reg_data = first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second    <= 1'b0;
      first_q   <= '0;
      vram_stb  <= 1'b0;
      vram_addr <= '0;
      vram_wr   <= 1'b0;
    end else begin
      vram_stb <= 1'b0;
      if (rd) begin
        second <= 1'b0;
      end else if (wr) begin
        if (!second) begin
          first_q <= wdata;
          second  <= 1'b1;
        end else begin
          second <= 1'b0;
          if (!wdata[DW-1]) begin
            vram_stb  <= 1'b1;
            vram_addr <= AW'({wdata[IDX_W-1:0], first_q});
            vram_wr   <= wdata[IDX_W];
          end
        end
      end
    end
  end

  assert_rd_rearms_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !second);

  assert_setup_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_stb |-> $past(wr && !rd && !wdata[DW-1]));
endmodule

// File: rtl/vdp_status_sel.sv
module vdp_status_sel
  import vdp_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NSTAT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  input  logic                  rd,
  input  logic [SEL_W-1:0]      sel,
  input  logic [DW-2:0]         s0_low,
  input  logic [(NSTAT-1)*DW-1:0] stat_in,
  output logic [DW-1:0]         rdata,
  output logic                  irq
);
  logic flag;
  logic clr;

  assign clr = rd && (sel == '0);
  assign irq = flag;

  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (frame_tick) flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  always_comb begin
    rdata = '1;
    if (sel == '0) rdata = {flag, s0_low};
    for (int k = 1; k < NSTAT; k++) begin
      if (sel == SEL_W'(k)) rdata = stat_in[(k-1)*DW +: DW];
    end
  end

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !frame_tick |=> !irq);
endmodule

// File: rtl/vdp_regfile.sv
module vdp_regfile
  import vdp_port_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               c_we,
  input  logic [IDX_W-1:0]   c_idx,
  input  logic [DW-1:0]      c_data,
  input  logic               i_valid,
  input  logic [DW-1:0]      i_data,
  output logic               i_ready,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               cmd_start
);
  logic [DW-1:0]    ind_reg;
  logic [IDX_W-1:0] i_idx;
  logic             i_inh;

  assign ind_reg = regs_flat[R_IND*DW +: DW];
  assign i_idx   = ind_reg[IDX_W-1:0];
  assign i_inh   = ind_reg[DW-1];
  assign i_ready = 1'b1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IMPL = (g < HOLE_LO) || (g > HOLE_HI);
    if (IMPL) begin : g_impl
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= '0;
        else if (c_we && c_idx == IDX_W'(g))
          q <= c_data;
        else if (i_valid && i_idx == IDX_W'(g))
          q <= i_data;
        else if (g == R_IND && i_valid && !i_inh)
          q <= {q[DW-1:IDX_W], q[IDX_W-1:0] + IDX_W'(1)};
      end
      assign regs_flat[g*DW +: DW] = q;
    end else begin : g_hole
      assign regs_flat[g*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_start <= 1'b0;
    else cmd_start <= (c_we && c_idx == IDX_W'(R_CMD)) ||
                      (i_valid && i_idx == IDX_W'(R_CMD));
  end

  assert_ind_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid && !i_inh && i_idx != IDX_W'(R_IND) && !(c_we && c_idx == IDX_W'(R_IND))
    |=> i_idx == IDX_W'($past(i_idx) + IDX_W'(1)));

  assert_ind_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid && i_inh && i_idx != IDX_W'(R_IND) && !(c_we && c_idx == IDX_W'(R_IND))
    |=> $stable(ind_reg));

  assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_we && c_idx == IDX_W'(R_CMD)
    |=> cmd_start && regs_flat[R_CMD*DW +: DW] == $past(c_data));
endmodule

// File: rtl/vdp_reg_port.sv
module vdp_reg_port
  import vdp_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREG  = 47,
  parameter int NSTAT = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_wr,
  input  logic [DW-1:0]           ctrl_wdata,
  input  logic                    ctrl_rd,
  output logic [DW-1:0]           ctrl_rdata,
  input  logic                    ind_valid,
  output logic                    ind_ready,
  input  logic [DW-1:0]           ind_data,
  input  logic                    frame_tick,
  input  logic [DW-2:0]           s0_flags,
  input  logic [(NSTAT-1)*DW-1:0] stat_in,
  output logic                    irq,
  output logic [NREG*DW-1:0]      regs_out,
  output logic [2:0]              vram_hi,
  output logic                    vram_setup_stb,
  output logic [IDX_W+DW-1:0]     vram_setup_addr,
  output logic                    vram_setup_wr,
  output logic                    cmd_start,
  output logic [3:0]              cmd_code,
  output logic [3:0]              cmd_logop
);
  logic             c_we;
  logic [IDX_W-1:0] c_idx;
  logic [DW-1:0]    c_data;
  logic [DW-1:0]    cmd_reg;

  vdp_ctrl_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata), .rd(ctrl_rd),
    .reg_we(c_we), .reg_idx(c_idx), .reg_data(c_data),
    .vram_stb(vram_setup_stb), .vram_addr(vram_setup_addr), .vram_wr(vram_setup_wr)
  );

  vdp_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .c_we(c_we), .c_idx(c_idx), .c_data(c_data),
    .i_valid(ind_valid), .i_data(ind_data), .i_ready(ind_ready),
    .regs_flat(regs_out), .cmd_start(cmd_start)
  );

  vdp_status_sel #(.DW(DW), .NSTAT(NSTAT)) u_stat (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rd(ctrl_rd),
    .sel(regs_out[R_STAT_SEL*DW +: SEL_W]), .s0_low(s0_flags), .stat_in(stat_in),
    .rdata(ctrl_rdata), .irq(irq)
  );

  assign cmd_reg   = regs_out[R_CMD*DW +: DW];
  assign cmd_code  = cmd_reg[DW-1 -: 4];
  assign cmd_logop = cmd_reg[3:0];
  assign vram_hi   = regs_out[R_VRAM_HI*DW +: 3];
endmodule

// File: tb/vdp_reg_port_test.sv
module vdp_reg_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_wr = 0, ctrl_rd = 0, ind_valid = 0, frame_tick = 0;
  logic [7:0]  ctrl_wdata = 0, ind_data = 0;
  logic [6:0]  s0_flags = 7'h25;
  logic [71:0] stat_in;
  logic [7:0]  ctrl_rdata;
  logic        ind_ready, irq, vram_setup_stb, vram_setup_wr, cmd_start;
  logic [375:0] regs_out;
  logic [2:0]  vram_hi;
  logic [13:0] vram_setup_addr;
  logic [3:0]  cmd_code, cmd_logop;

  int nchk = 0, nerr = 0;
  logic [7:0] expv [64];

  always #2 clk = ~clk;

  vdp_reg_port uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rd(ctrl_rd), .ctrl_rdata(ctrl_rdata), .ind_valid(ind_valid),
    .ind_ready(ind_ready), .ind_data(ind_data), .frame_tick(frame_tick),
    .s0_flags(s0_flags), .stat_in(stat_in), .irq(irq), .regs_out(regs_out),
    .vram_hi(vram_hi), .vram_setup_stb(vram_setup_stb),
    .vram_setup_addr(vram_setup_addr), .vram_setup_wr(vram_setup_wr),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_logop(cmd_logop)
  );

  function automatic bit impl(input int i);
    return (i < 24) || (i >= 32 && i <= 46);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int bad = -1;
    for (int i = 0; i < 47; i++)
      if (bad < 0 && regs_out[i*8 +: 8] !== expv[i]) bad = i;
    nchk++;
    if (bad >= 0) begin
      nerr++;
      $display("FAIL %s reg %0d actual %0h expected %0h", tag, bad,
               regs_out[bad*8 +: 8], expv[bad]);
    end
  endtask

  task automatic cwrite(input logic [7:0] b);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = b;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic setreg(input int idx, input logic [7:0] v);
    cwrite(v);
    cwrite(8'h80 | 8'(idx));
    if (impl(idx)) expv[idx] = v;
  endtask

  task automatic cread(output logic [7:0] d);
    @(negedge clk); ctrl_rd = 1; #1 d = ctrl_rdata;
    @(negedge clk); ctrl_rd = 0;
  endtask

  task automatic iwrite(input logic [7:0] v);
    int t;
    @(negedge clk); ind_valid = 1; ind_data = v;
    @(negedge clk); ind_valid = 0;
    t = int'(expv[17][5:0]);
    if (t == 17) expv[17] = v;
    else begin
      if (impl(t)) expv[t] = v;
      if (!expv[17][7]) expv[17][5:0] = expv[17][5:0] + 6'd1;
    end
  endtask

  initial begin
    #(4 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] d, e;
    for (int k = 0; k < 9; k++) stat_in[k*8 +: 8] = 8'(8'h11 * (k + 1));
    for (int i = 0; i < 64; i++) expv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check_all("R11 reset regs");
    chk(irq == 0, "R11 irq", irq, 0);
    chk(ind_ready == 1, "R11 ind_ready", ind_ready, 1);
    chk(ctrl_rdata == 8'h25, "R4 reset S0", ctrl_rdata, 8'h25);

    // R1 / R7 / R8 sweep of every index
    for (int n = 0; n < 64; n++) begin
      setreg(n, 8'(n * 37 + 5));
      check_all("R1 R7 sweep");
      if (n == 46) begin
        chk(cmd_start == 1, "R8 start ctrl", cmd_start, 1);
        chk(cmd_code == expv[46][7:4], "R8 code", cmd_code, expv[46][7:4]);
        chk(cmd_logop == expv[46][3:0], "R8 logop", cmd_logop, expv[46][3:0]);
      end
    end
    chk(vram_hi == expv[14][2:0], "R9 vram_hi", vram_hi, expv[14][2:0]);
    setreg(14, 8'hFD);
    chk(vram_hi == 3'd5, "R9 vram_hi 2", vram_hi, 5);

    // R2 address setup pairs
    cwrite(8'hA5); cwrite(8'h4C);
    chk(vram_setup_stb == 1, "R2 stb", vram_setup_stb, 1);
    chk(vram_setup_addr == {6'h0C, 8'hA5}, "R2 addr", vram_setup_addr, {6'h0C, 8'hA5});
    chk(vram_setup_wr == 1, "R2 wr", vram_setup_wr, 1);
    check_all("R2 no reg change");
    cwrite(8'h3C); cwrite(8'h12);
    chk(vram_setup_addr == {6'h12, 8'h3C}, "R2 addr b", vram_setup_addr, {6'h12, 8'h3C});
    chk(vram_setup_wr == 0, "R2 wr b", vram_setup_wr, 0);
    @(negedge clk);
    chk(vram_setup_stb == 0, "R2 one cycle", vram_setup_stb, 0);

    // R3 read re-arms pairing
    cwrite(8'h77);
    cread(d);
    setreg(3, 8'h5A);
    check_all("R3 rearm");

    // R4 status selector sweep
    for (int s = 0; s < 16; s++) begin
      setreg(15, 8'(s));
      cread(d);
      if (s == 0) e = {irq, 7'h25};
      else if (s < 10) e = 8'(8'h11 * s);
      else e = 8'hFF;
      chk(d == e, "R4 status sweep", d, e);
    end

    // R5 interrupt
    setreg(15, 8'h01);
    @(negedge clk); frame_tick = 1; @(negedge clk); frame_tick = 0;
    chk(irq == 1, "R5 set", irq, 1);
    cread(d);
    chk(irq == 1, "R5 held other read", irq, 1);
    setreg(15, 8'h00);
    cread(d);
    chk(d == 8'hA5, "R5 S0 flag", d, 8'hA5);
    chk(irq == 0, "R5 cleared", irq, 0);
    @(negedge clk); frame_tick = 1; ctrl_rd = 1;
    @(negedge clk); frame_tick = 0; ctrl_rd = 0;
    chk(irq == 1, "R5 set wins", irq, 1);
    cread(d);
    chk(irq == 0, "R5 cleared 2", irq, 0);

    // R6 indirect run, wrap, inhibit, self target
    setreg(17, 8'd20);
    iwrite(8'h01); iwrite(8'h02); iwrite(8'h03);
    check_all("R6 run");
    chk(regs_out[17*8 +: 6] == 6'd23, "R6 step", regs_out[17*8 +: 6], 23);
    setreg(17, 8'd62);
    iwrite(8'hE1); iwrite(8'hE2); iwrite(8'hE3); iwrite(8'hE4);
    check_all("R6 R7 wrap");
    setreg(17, 8'h85);
    iwrite(8'h44); iwrite(8'h55);
    check_all("R6 inhibit");
    chk(regs_out[5*8 +: 8] == 8'h55, "R6 inhibit target", regs_out[5*8 +: 8], 8'h55);
    setreg(17, 8'd46);
    iwrite(8'h9C);
    chk(cmd_start == 1, "R8 start ind", cmd_start, 1);
    chk(cmd_code == 4'h9 && cmd_logop == 4'hC, "R8 ind code", {cmd_code, cmd_logop}, 8'h9C);
    setreg(17, 8'd17);
    iwrite(8'h03);
    check_all("R6 self target");

    // R10 priorities
    setreg(17, 8'h88);
    cwrite(8'h11);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = 8'h88; ind_valid = 1; ind_data = 8'h22;
    @(negedge clk); ctrl_wr = 0; ind_valid = 0;
    expv[8] = 8'h11;
    check_all("R10 ctrl wins");
    cwrite(8'h44);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = 8'h83; ctrl_rd = 1;
    @(negedge clk); ctrl_wr = 0; ctrl_rd = 0;
    check_all("R10 rd drops wr");
    setreg(3, 8'h66);
    check_all("R10 pairing after drop");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule